// File: doc/BRIEF.md
# Masked Windowed Coincidence Trigger

This block turns a set of individual trigger lines into one coincidence decision. A programmable subset of the lines, the start set, may open a time window of programmable length, counted in 8 ns clocks. For as long as the window is open, every line that is seen high is recorded in a hit register. When the window has run its length, the recorded hits are compared against a second programmable subset, the require set. If every line of the require set was seen, the block emits a one-clock coincidence pulse.

The start and require sets are independent. A detector that is fast but noisy can therefore open the window while a slower set of detectors must all confirm. Examples: line 4 opens and lines 0, 2 and 4 are required; line 2 opens and lines 0 and 2 are required; line 2 opens and lines 1 and 2 are required; line 3 opens and lines 1 and 3 are required. All settings come from a single 32-bit control word that is held static while the block runs. The upper three input lines are normally tied low.

Top module: `coinc_window_trig`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `coincPulse` is 0 and `hitLatch` is 0.
- R2: The control word is decoded as follows: require set in bits 7:0, window length in bits 15:8, start set in bits 23:16. Bits 31:24 have no effect on behaviour.
- R3: A window opens only at a clock edge where the block is idle and a line whose start bit is set shows a rising edge, meaning it is high at this edge and was low at the previous edge. A rising line outside the start set opens nothing, and a start line held high opens a window only once.
- R4: A window with length L samples the inputs at L clock edges: the opening edge and the L-1 edges after it. A length of 0 behaves like a length of 1. A hit presented at the edge L after opening is not collected.
- R5: At every sampling edge the hit register takes the OR of itself and the input levels. `hitLatch` shows the accumulated value from the cycle after that edge onward.
- R6: At the edge L after opening, `coincPulse` rises for exactly one cycle if (hits AND require) equals require. Otherwise it stays 0.
- R7: Start-line rises that arrive while a window is open neither extend nor restart it.
- R8: The hit register clears at the closing edge. A new window may open at the very next edge, but a rise that lands on the closing edge itself is ignored.
- R9: With a require set of zero, the block never pulses.
- R10: The settings start 0x10/require 0x15, start 0x04/require 0x05, start 0x04/require 0x06 and start 0x08/require 0x0A fire when the required lines are hit inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 32 | Control word: require, length and start fields |
| trigIn | input | 8 | Trigger input lines, sampled as levels |
| coincPulse | output | 1 | One-cycle coincidence pulse |
| hitLatch | output | 8 | Hits accumulated in the current window |

## Verification
Let k be the edge that opens a window. `hitLatch` becomes valid in the cycle after k, and after each later sampling edge. The decision pulse appears in the cycle after edge k+L and lasts one cycle. The bench's driver records, for every window it opens, the cycle in which that pulse is due and its expected value. A monitor samples at the falling edge, compares at exactly that cycle, and flags any pulse that appears in a cycle with no expectation. The boundary cases place hits at edge k+L-1 and at edge k+L, and place a new rise at the closing edge and at the edge after it.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  // Strobes from the window sequencer to the hit datapath
  typedef struct packed {
    logic openNow;   // idle and a start rise: first sampling edge
    logic collect;   // window open, more sampling edges to come
    logic closeNow;  // window length reached: decide and clear
  } winStrobe_t;
endpackage

// File: rtl/coinc_win_ctrl.sv
module coinc_win_ctrl
  import coinc_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LEN_W-1:0] winLen,
  output winStrobe_t       strobe,
  output logic             winOpen
);
  logic [LEN_W-1:0] elapsed;
  logic             lastSample;

  // elapsed counts the sampling edges already taken; a length of 0 acts as 1
  always_comb begin
    lastSample      = (elapsed >= winLen);
    strobe.openNow  = !winOpen && startReq;
    strobe.closeNow = winOpen && lastSample;
    strobe.collect  = winOpen && !lastSample;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winOpen <= 1'b0;
      elapsed <= '0;
    end else if (strobe.openNow) begin
      winOpen <= 1'b1;
      elapsed <= LEN_W'(1);
    end else if (strobe.closeNow) begin
      winOpen <= 1'b0;
      elapsed <= '0;
    end else if (strobe.collect) begin
      elapsed <= elapsed + LEN_W'(1);
    end
  end
endmodule

// File: rtl/coinc_hit_path.sv
module coinc_hit_path
  import coinc_pkg::*;
#(
  parameter int NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] trigIn,
  input  logic [NUM_IN-1:0] startMask,
  input  logic [NUM_IN-1:0] reqMask,
  input  winStrobe_t        strobe,
  output logic              startReq,
  output logic [NUM_IN-1:0] hitLatch,
  output logic              coincPulse
);
  logic [NUM_IN-1:0] prevLvl;
  logic [NUM_IN-1:0] riseVec;
  logic              reqMet;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevLvl[i]  <= 1'b0;
        hitLatch[i] <= 1'b0;
      end else begin
        prevLvl[i] <= trigIn[i];
        if (strobe.openNow)       hitLatch[i] <= trigIn[i];
        else if (strobe.collect)  hitLatch[i] <= hitLatch[i] | trigIn[i];
        else if (strobe.closeNow) hitLatch[i] <= 1'b0;
      end
    end
    assign riseVec[i] = trigIn[i] & ~prevLvl[i];
  end

  assign startReq = |(riseVec & startMask);
  assign reqMet   = (reqMask != '0) && ((hitLatch & reqMask) == reqMask);

  always_ff @(posedge clk) begin
    if (!rstN) coincPulse <= 1'b0;
    else       coincPulse <= strobe.closeNow && reqMet;
  end
endmodule

// File: rtl/coinc_window_trig.sv
module coinc_window_trig
  import coinc_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int LEN_W  = 8,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic [NUM_IN-1:0] trigIn,
  output logic              coincPulse,
  output logic [NUM_IN-1:0] hitLatch
);
  localparam int REQ_LSB   = 0;
  localparam int LEN_LSB   = REQ_LSB + NUM_IN;
  localparam int START_LSB = LEN_LSB + LEN_W;
  localparam int USED_W    = START_LSB + NUM_IN;

  winStrobe_t strobe;
  logic       startReq;
  logic       winOpen;
  logic       unusedCfgBits;

  assign unusedCfgBits = ^cfgWord[CFG_W-1:USED_W];

  coinc_win_ctrl #(.LEN_W(LEN_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .winLen   (cfgWord[LEN_LSB +: LEN_W]),
    .strobe   (strobe),
    .winOpen  (winOpen)
  );

  coinc_hit_path #(.NUM_IN(NUM_IN)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .trigIn     (trigIn),
    .startMask  (cfgWord[START_LSB +: NUM_IN]),
    .reqMask    (cfgWord[REQ_LSB +: NUM_IN]),
    .strobe     (strobe),
    .startReq   (startReq),
    .hitLatch   (hitLatch),
    .coincPulse (coincPulse)
  );
endmodule

// File: rtl/coinc_window_chk.sv
module coinc_window_chk #(
  parameter int NUM_IN = 8,
  parameter int LEN_W  = 8,
  parameter int CFG_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [CFG_W-1:0]  cfgWord,
  input logic [NUM_IN-1:0] trigIn,
  input logic              coincPulse,
  input logic [NUM_IN-1:0] hitLatch,
  input logic              winOpen
);
  localparam int START_LSB = NUM_IN + LEN_W;

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    coincPulse |=> !coincPulse);

  // R8
  hits_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    coincPulse |-> (hitLatch == '0) && !winOpen);

  // R9
  req_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    coincPulse |-> ($past(cfgWord[NUM_IN-1:0]) != '0));

  // R3
  open_by_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(winOpen) |-> ($past(trigIn & cfgWord[START_LSB +: NUM_IN]) != '0));

  // R5
  hits_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winOpen && $past(winOpen)) |-> ((hitLatch & $past(hitLatch)) == $past(hitLatch)));

  // R1
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    !winOpen |-> (hitLatch == '0));
endmodule

bind coinc_window_trig coinc_window_chk #(.NUM_IN(NUM_IN), .LEN_W(LEN_W), .CFG_W(CFG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWord    (cfgWord),
  .trigIn     (trigIn),
  .coincPulse (coincPulse),
  .hitLatch   (hitLatch),
  .winOpen    (winOpen)
);

// File: tb/sim_coinc_window_trig.sv
`timescale 1ns/1ps
module sim_coinc_window_trig;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgWord = '0;
  logic [7:0]  trigIn = '0;
  logic        coincPulse;
  logic [7:0]  hitLatch;

  int  cyc = 0;
  int  nChecks = 0;
  int  nFails = 0;
  bit  monOn = 1'b0;
  bit  finished = 1'b0;

  typedef struct { int due; bit want; string tag; } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  coinc_window_trig u0 (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .trigIn(trigIn),
    .coincPulse(coincPulse), .hitLatch(hitLatch)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: compares the pulse in the cycle it is due, flags unexpected pulses
  always @(negedge clk) begin
    if (monOn) begin
      if (expQ.size() != 0 && expQ[0].due == cyc) begin
        check(coincPulse == expQ[0].want, expQ[0].tag, coincPulse, expQ[0].want);
        void'(expQ.pop_front());
      end else if (coincPulse) begin
        check(1'b0, "R6 unexpected pulse", coincPulse, 0);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [31:0] mkCfg(input logic [7:0] st, input logic [7:0] len, input logic [7:0] rq);
    return {8'h00, st, len, rq};
  endfunction

  // Opens a window with opener, optionally presents late at edge k+lateOff
  task automatic runWin(input logic [31:0] cfg, input logic [7:0] opener, input int len,
                        input logic [7:0] late, input int lateOff, input bit want, input string tag);
    int effLen = (len == 0) ? 1 : len;
    int k;
    cfgWord = cfg;
    tick();
    trigIn = opener;
    k = cyc + 1;
    expQ.push_back('{k + effLen, want, tag});
    for (int o = 1; o <= effLen + 1; o++) begin
      tick();
      if (o == 1) check(hitLatch == opener, "R5 opening hits", hitLatch, opener);
      if (lateOff > 0 && lateOff < effLen && o == lateOff + 1)
        check(hitLatch == (opener | late), "R5 accumulated hits", hitLatch, opener | late);
      trigIn = (o == lateOff) ? late : 8'h00;
    end
    repeat (4) tick();
    check(hitLatch == 8'h00, "R8 hits cleared after close", hitLatch, 0);
  endtask

  initial begin
    repeat (3) tick();
    check(coincPulse == 1'b0, "R1 pulse in reset", coincPulse, 0);
    check(hitLatch == 8'h00, "R1 hits in reset", hitLatch, 0);
    rstN = 1'b1;
    monOn = 1'b1;
    tick();
    check(coincPulse == 1'b0 && hitLatch == 8'h00, "R1 after reset", {hitLatch, 7'b0, coincPulse}, 0);

    // R10 examples
    runWin(mkCfg(8'h10, 8'd4, 8'h15), 8'h10, 4, 8'h05, 2, 1'b1, "R10 start10 req15");
    runWin(mkCfg(8'h04, 8'd3, 8'h05), 8'h05, 3, 8'h00, 0, 1'b1, "R10 start04 req05");
    runWin(mkCfg(8'h04, 8'd5, 8'h06), 8'h04, 5, 8'h02, 4, 1'b1, "R10 R4 start04 req06 hit at L-1");
    runWin(mkCfg(8'h08, 8'd5, 8'h0A), 8'h08, 5, 8'h02, 5, 1'b0, "R4 hit at closing edge missed");
    runWin(mkCfg(8'h08, 8'd5, 8'h0A), 8'h08, 5, 8'h02, 3, 1'b1, "R10 start08 req0A");
    // R9 zero require
    runWin(mkCfg(8'h01, 8'd2, 8'h00), 8'hFF, 2, 8'h00, 0, 1'b0, "R9 require zero");
    // R4 length zero acts as one
    runWin(mkCfg(8'h01, 8'd0, 8'h01), 8'h01, 0, 8'h00, 0, 1'b1, "R4 length zero");
    // R2 upper bits ignored
    runWin(mkCfg(8'h02, 8'd3, 8'h03) | 32'hFF00_0000, 8'h02, 3, 8'h01, 1, 1'b1, "R2 upper bits ignored");
    // R6 missing required line
    runWin(mkCfg(8'h01, 8'd4, 8'h03), 8'h01, 4, 8'h00, 0, 1'b0, "R6 required line missing");
    // R7 start rise inside window does not extend
    runWin(mkCfg(8'h03, 8'd4, 8'h03), 8'h01, 4, 8'h02, 2, 1'b1, "R7 no extension");

    // R3 non-start line rises: nothing opens
    cfgWord = mkCfg(8'h01, 8'd2, 8'h02);
    tick(); trigIn = 8'h02;
    tick(); trigIn = 8'h00;
    repeat (5) tick();
    check(hitLatch == 8'h00, "R3 non-start line opens nothing", hitLatch, 0);

    // R3 held-high start line opens only once
    begin
      int k;
      cfgWord = mkCfg(8'h01, 8'd2, 8'h01);
      tick(); trigIn = 8'h01; k = cyc + 1;
      expQ.push_back('{k + 2, 1'b1, "R3 held line single window"});
      repeat (10) tick();
      check(hitLatch == 8'h00, "R3 held line no reopen", hitLatch, 0);
      trigIn = 8'h00;
      repeat (4) tick();
    end

    // R8 reopen on the edge after closing
    begin
      int k;
      cfgWord = mkCfg(8'h01, 8'd2, 8'h01);
      tick(); trigIn = 8'h01; k = cyc + 1;
      expQ.push_back('{k + 2, 1'b1, "R8 first window"});
      expQ.push_back('{k + 5, 1'b1, "R8 reopen next edge"});
      tick(); trigIn = 8'h00;
      tick(); trigIn = 8'h00;
      tick(); trigIn = 8'h01;
      tick(); trigIn = 8'h00;
      repeat (6) tick();
    end

    // R8 rise on the closing edge is ignored
    begin
      int k;
      tick(); trigIn = 8'h01; k = cyc + 1;
      expQ.push_back('{k + 2, 1'b1, "R8 window before closing-edge rise"});
      tick(); trigIn = 8'h00;
      tick(); trigIn = 8'h01;
      tick(); trigIn = 8'h00;
      repeat (3) tick();
      check(hitLatch == 8'h00, "R8 closing-edge rise ignored", hitLatch, 0);
      repeat (4) tick();
    end

    check(expQ.size() == 0, "R6 all expected pulses seen", expQ.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end
endmodule